// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block hands a shared bus to one of several masters. Every master drives its own request bit. The arbiter merges these bits into one shared request, modelled as a logical OR. While the bus is free and that merged request is high, the arbiter sends a single grant token into a chain of stages. The token enters at master 0, which has the highest priority, and moves toward master N-1, which has the lowest. A master that is not requesting passes the token on. The first master that is requesting keeps the token, and the arbiter latches it as the bus owner.

Ownership lasts until the owning master pulses its release line. The owner's request bit does not end ownership: dropping it has no effect, and no higher-priority request can take the bus away. After a release the bus is free for one cycle. In that cycle the arbiter looks at the merged request again, and any new grant appears on the following edge. The block has no fairness scheme. A master low in the chain can wait for ever if masters above it keep asking.

Top module: `dca_arbiter`

## Requirements
- R1: During reset, and until the first request after reset, every grant output is 0 and busy_o is 0.
- R2: If the bus is free and at least one request bit is set at a rising edge, then after that edge exactly one grant bit is set and busy_o is 1.
- R3: The grant goes to the requesting master with the lowest index. Index 0 has the highest priority and bit i of gnt_o belongs to master i. At most one grant bit is ever set.
- R4: If the bus is free and no request bit is set at a rising edge, then the bus stays free after that edge.
- R5: While the bus is owned and the owner's release bit is 0, the grant stays unchanged, whatever the request bits do. This includes the owner dropping its request and a higher-priority master asking.
- R6: If the owner's release bit is 1 at a rising edge, then after that edge all grant bits are 0 and busy_o is 0. A new grant can appear one edge later at the earliest.
- R7: A release bit from a master that does not own the bus has no effect, whether the bus is free or owned by another master.
- R8: A lower-priority master never receives the grant while a higher-priority master is requesting at each moment the bus becomes free. Starvation is allowed.
- R9: busy_o is 1 exactly when one grant bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously inside the block. |
| req_i | input | NUM_MASTERS | Per-master bus request. Bit 0 has the highest priority. |
| rel_i | input | NUM_MASTERS | Per-master release of an owned bus |
| gnt_o | output | NUM_MASTERS | Per-master grant, at most one bit set |
| busy_o | output | 1 | The bus has an owner |

## Verification
Two cases are hard to reach from the ports. The first is the free cycle that follows a release, when several masters are requesting together and a release from some other master arrives at the same moment. The second is starvation, where the lowest master keeps asking through repeated hand-overs among the masters above it. Seeded random requests keep many masters asking at once, and release bits are sprinkled over owners and non-owners alike. Directed sequences add a pre-emption attempt, the owner dropping its request, stray releases and a starvation run. Every cycle is compared with a bench model of the priority order.

// File: rtl/dca_pkg.sv
package dca_pkg;
  typedef enum logic {
    ARB_FREE = 1'b0,
    ARB_HELD = 1'b1
  } arb_state_e;
endpackage

// File: rtl/dca_rst_sync.sv
module dca_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dca_cell.sv
module dca_cell (
  input  logic tok_in,
  input  logic want,
  output logic keep,
  output logic tok_out
);
  // A requesting stage keeps the token; an idle one passes it on.
  assign keep    = tok_in & want;
  assign tok_out = tok_in & ~want;
endmodule

// File: rtl/dca_chain.sv
module dca_chain #(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tok_in,
  input  logic [NUM_MASTERS-1:0] want,
  output logic [NUM_MASTERS-1:0] keep
);
  logic [NUM_MASTERS:0] tok;

  assign tok[0] = tok_in;

  for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_stage
    dca_cell u_cell (
      .tok_in (tok[i]),
      .want   (want[i]),
      .keep   (keep[i]),
      .tok_out(tok[i+1])
    );
  end

  // R3: a single token can be absorbed by at most one stage
  p_single_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(keep));

  // R3: a token that leaves the end of the chain means nobody asked for it
  p_token_unclaimed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tok[NUM_MASTERS] |-> (want == '0));
endmodule

// File: rtl/dca_owner_reg.sv
module dca_owner_reg
  import dca_pkg::*;
#(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] keep,
  input  logic [NUM_MASTERS-1:0] rel,
  input  logic                   any_req,
  output logic [NUM_MASTERS-1:0] owner,
  output logic                   busy
);
  arb_state_e               state_q, state_d;
  logic [NUM_MASTERS-1:0]   owner_q, owner_d;
  logic                     owner_rel;
  logic                     load_en;

  assign owner_rel = |(rel & owner_q);

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    load_en = 1'b0;
    unique case (state_q)
      ARB_FREE: begin
        if (keep != '0) begin
          load_en = 1'b1;
          state_d = ARB_HELD;
          owner_d = keep;
        end
      end
      ARB_HELD: begin
        if (owner_rel) begin
          load_en = 1'b1;
          state_d = ARB_FREE;
          owner_d = '0;
        end
      end
      default: begin
        load_en = 1'b1;
        state_d = ARB_FREE;
        owner_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_FREE;
      owner_q <= '0;
    end else if (load_en) begin
      state_q <= state_d;
      owner_q <= owner_d;
    end
  end

  assign owner = owner_q;
  assign busy  = (state_q == ARB_HELD);

  // R3: never more than one owner
  p_one_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner_q));

  // R9: the state and the owner vector agree
  p_busy_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (owner_q != '0));

  // R2: a free bus with a pending request is granted at the next edge
  p_grant_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && any_req) |=> busy);

  // R4: nothing is granted without a request
  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !any_req) |=> !busy);

  // R5: ownership holds until the owner releases
  p_hold_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !owner_rel) |=> $stable(owner_q));

  // R6: owner release frees the bus at the next edge
  p_release_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && owner_rel) |=> (!busy && owner_q == '0));
endmodule

// File: rtl/dca_arbiter.sv
module dca_arbiter #(
  parameter int NUM_MASTERS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_MASTERS-1:0] req_i,
  input  logic [NUM_MASTERS-1:0] rel_i,
  output logic [NUM_MASTERS-1:0] gnt_o,
  output logic                   busy_o
);
  logic                   rst_sync_n;
  logic                   shared_req;
  logic                   chain_tok;
  logic [NUM_MASTERS-1:0] keep;
  logic [NUM_MASTERS-1:0] owner;
  logic                   busy;

  dca_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // Wired-OR request line, modelled as a reduction OR
  assign shared_req = |req_i;
  // A token is issued only while the bus has no owner
  assign chain_tok  = shared_req & ~busy;

  dca_chain #(.NUM_MASTERS(NUM_MASTERS)) u_chain (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .tok_in(chain_tok),
    .want  (req_i),
    .keep  (keep)
  );

  dca_owner_reg #(.NUM_MASTERS(NUM_MASTERS)) u_owner (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .keep   (keep),
    .rel    (rel_i),
    .any_req(shared_req),
    .owner  (owner),
    .busy   (busy)
  );

  assign gnt_o  = owner;
  assign busy_o = busy;
endmodule

// File: tb/dca_arbiter_test.sv
module dca_arbiter_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] rel = '0;
  logic [N-1:0] gnt;
  logic         busy;

  int vectors = 0;
  int errors  = 0;
  int model_owner = -1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dca_arbiter #(.NUM_MASTERS(N)) uut (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req),
    .rel_i (rel),
    .gnt_o (gnt),
    .busy_o(busy)
  );

  function automatic int next_owner(int cur, logic [N-1:0] rq, logic [N-1:0] rl);
    if (cur >= 0) return rl[cur] ? -1 : cur;
    for (int i = 0; i < N; i++) if (rq[i]) return i;
    return -1;
  endfunction

  function automatic logic [N-1:0] gnt_of(int own);
    return (own < 0) ? '0 : (N'(1) << own);
  endfunction

  task automatic check(string tag, logic [N-1:0] exp_g);
    vectors++;
    if (gnt !== exp_g || busy !== (exp_g != '0)) begin
      errors++;
      $display("FAIL %s: gnt=%b busy=%b expected gnt=%b busy=%b",
               tag, gnt, busy, exp_g, exp_g != '0);
    end
    vectors++;
    if ($countones(gnt) > 1 || busy !== (gnt != '0)) begin
      errors++;
      $display("FAIL R3/R9: gnt=%b busy=%b expected onehot0 with busy=|gnt",
               gnt, busy);
    end
  endtask

  // Drive one cycle of inputs after a falling edge, check at the next one.
  task automatic step(logic [N-1:0] rq, logic [N-1:0] rl, string tag);
    int    nxt;
    string t;
    req = rq;
    rel = rl;
    nxt = next_owner(model_owner, rq, rl);
    if (tag != "") t = tag;
    else if (model_owner < 0) t = (rq != '0) ? "R2" : "R4";
    else if (rl[model_owner]) t = "R6";
    else if (rl != '0) t = "R7";
    else t = "R5";
    @(negedge clk);
    model_owner = nxt;
    check(t, gnt_of(model_owner));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_0A1B));
    // R1: reset holds grants low even with requests present
    req = '1;
    repeat (3) @(negedge clk);
    check("R1", '0);
    req = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", '0);

    // R4: idle with stray release stays free (R7)
    step('0, '1, "R7");
    step('0, '0, "R4");
    // R3: lowest index requester wins
    step(4'b1100, '0, "R3");          // master 2
    // R5: higher priority asks, owner drops request
    step(4'b0001, '0, "R5");
    step(4'b0000, '0, "R5");
    // R7: non-owner release ignored
    step(4'b0001, 4'b1011, "R7");
    // R6: owner release, then a free cycle, then master 0
    step(4'b0001, 4'b0100, "R6");
    step(4'b0001, '0, "R6");
    // R8: masters 1 and 3 keep asking; 1 always wins
    for (int k = 0; k < 4; k++) begin
      step(4'b1010, 4'b0001, "R8");
      step(4'b1010, 4'b0000, "R8");
      step(4'b1010, 4'b0010, "R8");
      step(4'b1010, 4'b0000, "R8");
    end
    step('0, 4'b0010, "R6");
    step('0, '0, "R4");
    // master 3 gets it once alone
    step(4'b1000, '0, "R3");
    step(4'b0000, 4'b1000, "R6");

    // Random mix
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] rq, rl;
      rq = N'($urandom);
      rl = (($urandom % 4) == 0) ? N'($urandom) : '0;
      step(rq, rl, "");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule